// File: doc/BRIEF.md
# Privileged Register Access Checker

This block decides what happens when software tries to read or write one hypervisor-level 64-bit trap-configuration register. For every request it looks at the requesting privilege level (0 to 3), whether the hypervisor level is enabled, two nested-virtualization control bits, whether the top privilege level exists, the top level's enable for fine-grained traps, and the debug-halt state with its secure-debug-disable flag. It then selects exactly one outcome: undefined, trap to level 2, trap to level 3, redirect to a memory offset, or direct access.

The decision itself is combinational and settles in the same cycle as the request. The block also holds the register. Only bits 2 and 0 are implemented. A write is committed on the next rising clock edge, and only when its outcome is direct access. A read returns the register in the same cycle, and only when its outcome is direct access. The block does not decode instructions, write syndrome state or perform the redirected memory transaction. It only reports the exception class or the byte offset those stages need.

A parameter selects whether the level-2 debug-lock check is evaluated before the other level-2 checks. For this register both orderings give the same result on every input combination.

Top module: `trapcfg_access_gate`

## Requirements
- R1: While `req_valid` is 1, `outcome` has exactly one bit set, using these positions: bit0 undefined, bit1 trap to level 2, bit2 trap to level 3, bit3 memory redirect, bit4 direct access. While `req_valid` is 0, `outcome` is all zero.
- R2: A request at privilege level 0 always gives undefined.
- R3: At level 1, with the hypervisor enabled and both nested-virtualization bits set, the outcome is memory redirect and `mem_offset` is 0x2C8.
- R4: At level 1, with the hypervisor enabled, `nv_bit` set and `nv2_bit` clear, the outcome is trap to level 2 and `exc_class` is 0x18.
- R5: At level 1, every other combination gives undefined. This includes the hypervisor being disabled and `nv2_bit` being set without `nv_bit`.
- R6: At level 2, when the top level is present and its fine-grained-trap enable is 0, and the core is not both halted and secure-debug-disabled, the outcome is trap to level 3 with `exc_class` 0x18.
- R7: At level 2, when the top level is present, its enable is 0, the core is halted and secure-debug-disable is set, the outcome is undefined for either setting of the priority parameter.
- R8: At level 2 with no blocking condition the outcome is direct access. At level 3 it is always direct access.
- R9: `exc_class` is 0x18 only on trap outcomes and 0 otherwise. `mem_offset` is 0x2C8 only on redirect and 0 otherwise.
- R10: The register resets to zero. A direct-access write stores only bits 2 and 0 of the write data. Every other bit always reads as zero.
- R11: A write whose outcome is not direct access leaves the register unchanged.
- R12: `rdata` carries the register on a direct-access read and is zero on every other outcome, including writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level enabled in the current security state |
| nv_bit | input | 1 | Nested-virtualization control |
| nv2_bit | input | 1 | Nested-virtualization memory-redirect control |
| top_present | input | 1 | Top privilege level (3) implemented |
| fgt_en | input | 1 | Top level's fine-grained-trap enable |
| halted | input | 1 | Core is in debug halt |
| sdd | input | 1 | Secure-debug-disable flag |
| wdata | input | 64 | Write data |
| outcome | output | 5 | One-hot outcome (R1 encoding) |
| exc_class | output | 8 | Exception class on trap outcomes, else 0 |
| mem_offset | output | 12 | Redirect byte offset on redirect, else 0 |
| rdata | output | 64 | Register value on a direct read, else 0 |

## Verification
At level 1, each cell of the hypervisor-enable, nv and nv2 truth table is applied, so that redirect, trap and undefined are separated by the nested-virtualization bits alone. At level 2, the top-present, enable, halted and secure-debug-disable inputs are toggled one at a time. The same stimulus drives a second instance built with the early debug-lock ordering, which shows that both orderings agree. The register is written with all ones and with patterns that avoid bits 2 and 0, and writes are blocked by trap outcomes. The readback after each of these separates the kept bits, the reserved-bit masking and the dropped writes.

// File: rtl/trapcfg_pkg.sv
// Package: shared outcome encoding and constants for the trap-configuration
// register access gate. Assumes one request per cycle at most.
package trapcfg_pkg;
    // One-hot outcome codes; bit positions are part of the port contract.
    typedef enum logic [4:0] {
        OC_NONE   = 5'b00000,
        OC_UNDEF  = 5'b00001,
        OC_TRAP2  = 5'b00010,
        OC_TRAP3  = 5'b00100,
        OC_REDIR  = 5'b01000,
        OC_DIRECT = 5'b10000
    } outcome_e;

    localparam int          EC_W         = 8;
    localparam int          OFF_W        = 12;
    localparam logic [7:0]  EC_SYSREG    = 8'h18;
    localparam logic [11:0] REDIR_OFFSET = 12'h2C8;
endpackage

// File: rtl/trapcfg_decide.sv
// Module: access decision. Maps request context to one outcome code.
// Assumes inputs are stable for the cycle; purely combinational.
// EARLY_LOCK selects whether the debug-lock test leads the level-2 chain.
module trapcfg_decide
    import trapcfg_pkg::*;
#(
    parameter bit EARLY_LOCK = 1'b0
) (
    input  logic       req_valid,
    input  logic [1:0] priv_lvl,
    input  logic       hyp_en,
    input  logic       nv_bit,
    input  logic       nv2_bit,
    input  logic       top_present,
    input  logic       fgt_en,
    input  logic       halted,
    input  logic       sdd,
    output outcome_e   oc
);
    logic     top_block;
    logic     dbg_lock;
    outcome_e lvl1_oc;
    outcome_e lvl2_oc;

    assign top_block = top_present && !fgt_en;
    assign dbg_lock  = halted && sdd;

    // Level-1 chain: redirect, then hypervisor trap, else undefined.
    always_comb begin
        if (hyp_en && nv_bit && nv2_bit)
            lvl1_oc = OC_REDIR;
        else if (hyp_en && nv_bit)
            lvl1_oc = OC_TRAP2;
        else
            lvl1_oc = OC_UNDEF;
    end

    // Level-2 chain; the ordering variant is picked by parameter.
    generate
        if (EARLY_LOCK) begin : g_early
            always_comb begin
                if (dbg_lock && top_block)
                    lvl2_oc = OC_UNDEF;
                else if (top_block)
                    lvl2_oc = OC_TRAP3;
                else
                    lvl2_oc = OC_DIRECT;
            end
        end else begin : g_late
            always_comb begin
                if (top_block)
                    lvl2_oc = dbg_lock ? OC_UNDEF : OC_TRAP3;
                else
                    lvl2_oc = OC_DIRECT;
            end
        end
    endgenerate

    // Final selection by privilege level.
    always_comb begin
        if (!req_valid) begin
            oc = OC_NONE;
        end else begin
            unique case (priv_lvl)
                2'd0:    oc = OC_UNDEF;
                2'd1:    oc = lvl1_oc;
                2'd2:    oc = lvl2_oc;
                default: oc = OC_DIRECT;
            endcase
        end
    end
endmodule

// File: rtl/trapcfg_result_fmt.sv
// Module: side-band formatter. Produces the exception class and redirect
// offset from the outcome code; each is zero unless its outcome is active.
module trapcfg_result_fmt
    import trapcfg_pkg::*;
#(
    parameter logic [EC_W-1:0]  EC_VALUE  = EC_SYSREG,
    parameter logic [OFF_W-1:0] OFF_VALUE = REDIR_OFFSET
) (
    input  outcome_e          oc,
    output logic [EC_W-1:0]   exc_class,
    output logic [OFF_W-1:0]  mem_offset
);
    // Exception class only on either trap outcome.
    always_comb begin
        exc_class = (oc == OC_TRAP2 || oc == OC_TRAP3) ? EC_VALUE : '0;
    end

    // Offset only on memory redirect.
    always_comb begin
        mem_offset = (oc == OC_REDIR) ? OFF_VALUE : '0;
    end
endmodule

// File: rtl/trapcfg_store.sv
// Module: register storage with reserved-bit masking. Only bits set in
// KEEP_MASK are stored; others are held at zero. Synchronous active-low reset.
module trapcfg_store #(
    parameter int           W         = 64,
    parameter logic [W-1:0] KEEP_MASK = 64'h5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    logic [W-1:0] reg_q;

    // Capture masked write data on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (wr_en)
            reg_q <= wdata & KEEP_MASK;
    end

    assign value = reg_q;
endmodule

// File: rtl/trapcfg_access_gate.sv
// Module: top of the register access gate. Decides the outcome of each
// request, formats side-band fields, and owns the register. Assumes at most
// one request per cycle; writes commit on the next clock edge.
module trapcfg_access_gate
    import trapcfg_pkg::*;
#(
    parameter int           REG_W      = 64,
    parameter logic [REG_W-1:0] KEEP_MASK = 64'h5,
    parameter bit           EARLY_LOCK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       priv_lvl,
    input  logic             hyp_en,
    input  logic             nv_bit,
    input  logic             nv2_bit,
    input  logic             top_present,
    input  logic             fgt_en,
    input  logic             halted,
    input  logic             sdd,
    input  logic [REG_W-1:0] wdata,
    output logic [4:0]       outcome,
    output logic [EC_W-1:0]  exc_class,
    output logic [OFF_W-1:0] mem_offset,
    output logic [REG_W-1:0] rdata
);
    outcome_e         oc;
    logic             is_direct;
    logic             wr_en;
    logic [REG_W-1:0] stored_q;

    trapcfg_decide #(.EARLY_LOCK(EARLY_LOCK)) u_decide (
        .req_valid   (req_valid),
        .priv_lvl    (priv_lvl),
        .hyp_en      (hyp_en),
        .nv_bit      (nv_bit),
        .nv2_bit     (nv2_bit),
        .top_present (top_present),
        .fgt_en      (fgt_en),
        .halted      (halted),
        .sdd         (sdd),
        .oc          (oc)
    );

    trapcfg_result_fmt u_fmt (
        .oc         (oc),
        .exc_class  (exc_class),
        .mem_offset (mem_offset)
    );

    assign is_direct = (oc == OC_DIRECT);
    assign wr_en     = is_direct && req_write;

    trapcfg_store #(.W(REG_W), .KEEP_MASK(KEEP_MASK)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .value (stored_q)
    );

    // Present the register only on a direct-access read.
    always_comb begin
        rdata = (is_direct && !req_write) ? stored_q : '0;
    end

    assign outcome = oc;
endmodule

// File: rtl/trapcfg_access_checker.sv
// Module: property checker bound to the access gate.
module trapcfg_access_checker #(
    parameter int               REG_W     = 64,
    parameter logic [REG_W-1:0] KEEP_MASK = 64'h5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       priv_lvl,
    input logic [4:0]       outcome,
    input logic [7:0]       exc_class,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] stored_q
);
    logic wr_taken;
    assign wr_taken = req_valid && req_write && outcome[4];

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(outcome) == 1);                          // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> outcome == 5'b0);                                  // R1
    AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_lvl == 2'd0) |-> outcome == 5'b00001);         // R2
    AST_EL3_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_lvl == 2'd3) |-> outcome == 5'b10000);         // R8
    AST_EC_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_class != 8'h0) |-> (outcome[1] || outcome[2]));              // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stored_q & ~KEEP_MASK) == '0);                                   // R10
    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_taken |=> stored_q == ($past(wdata) & KEEP_MASK));             // R10
    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_taken |=> $stable(stored_q));                                 // R11
endmodule

bind trapcfg_access_gate trapcfg_access_checker #(
    .REG_W(REG_W), .KEEP_MASK(KEEP_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .priv_lvl  (priv_lvl),
    .outcome   (outcome),
    .exc_class (exc_class),
    .wdata     (wdata),
    .stored_q  (stored_q)
);

// File: tb/test_trapcfg_access_gate.sv
// Directed bench: one task per scenario, each checking its own results.
module test_trapcfg_access_gate;
    localparam logic [4:0] E_NONE = 5'b00000, E_UND = 5'b00001, E_T2 = 5'b00010,
                           E_T3 = 5'b00100, E_RED = 5'b01000, E_DIR = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] priv_lvl = 2'd0;
    logic hyp_en = 1'b0, nv_bit = 1'b0, nv2_bit = 1'b0;
    logic top_present = 1'b0, fgt_en = 1'b0, halted = 1'b0, sdd = 1'b0;
    logic [63:0] wdata = '0;
    logic [4:0]  outcome, outcome_e2;
    logic [7:0]  exc_class, exc_class_e2;
    logic [11:0] mem_offset, mem_offset_e2;
    logic [63:0] rdata, rdata_e2;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    trapcfg_access_gate i_trapcfg_access_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .priv_lvl(priv_lvl), .hyp_en(hyp_en), .nv_bit(nv_bit), .nv2_bit(nv2_bit),
        .top_present(top_present), .fgt_en(fgt_en), .halted(halted), .sdd(sdd),
        .wdata(wdata), .outcome(outcome), .exc_class(exc_class),
        .mem_offset(mem_offset), .rdata(rdata));

    trapcfg_access_gate #(.EARLY_LOCK(1'b1)) i_trapcfg_access_gate_early (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .priv_lvl(priv_lvl), .hyp_en(hyp_en), .nv_bit(nv_bit), .nv2_bit(nv2_bit),
        .top_present(top_present), .fgt_en(fgt_en), .halted(halted), .sdd(sdd),
        .wdata(wdata), .outcome(outcome_e2), .exc_class(exc_class_e2),
        .mem_offset(mem_offset_e2), .rdata(rdata_e2));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply a request at the falling edge, let logic settle.
    task automatic req(input logic [1:0] lvl, input logic hy, input logic n1, input logic n2,
                       input logic tp, input logic fe, input logic hl, input logic sd,
                       input logic wr, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; priv_lvl = lvl; hyp_en = hy;
        nv_bit = n1; nv2_bit = n2; top_present = tp; fgt_en = fe;
        halted = hl; sdd = sd; wdata = wd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic t_reset();
        idle();
        check("R1 idle outcome zero", {59'b0, outcome}, {59'b0, E_NONE});
        req(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        check("R10 reset value zero", rdata, 64'h0);
    endtask

    task automatic t_level0();
        req(2'd0, 1, 1, 1, 1, 1, 0, 0, 0, '0);
        check("R2 level0 undefined", {59'b0, outcome}, {59'b0, E_UND});
        check("R9 no class on undefined", {56'b0, exc_class}, 64'h0);
    endtask

    task automatic t_level1();
        req(2'd1, 1, 1, 1, 0, 0, 0, 0, 0, '0);
        check("R3 redirect outcome", {59'b0, outcome}, {59'b0, E_RED});
        check("R3 redirect offset", {52'b0, mem_offset}, 64'h2C8);
        check("R9 no class on redirect", {56'b0, exc_class}, 64'h0);
        req(2'd1, 1, 1, 0, 0, 0, 0, 0, 0, '0);
        check("R4 trap to level2", {59'b0, outcome}, {59'b0, E_T2});
        check("R4 class 0x18", {56'b0, exc_class}, 64'h18);
        check("R9 no offset on trap", {52'b0, mem_offset}, 64'h0);
        req(2'd1, 1, 0, 1, 0, 0, 0, 0, 0, '0);
        check("R5 nv2 without nv undefined", {59'b0, outcome}, {59'b0, E_UND});
        req(2'd1, 0, 1, 1, 0, 0, 0, 0, 0, '0);
        check("R5 hyp disabled undefined", {59'b0, outcome}, {59'b0, E_UND});
    endtask

    task automatic t_level2();
        req(2'd2, 1, 0, 0, 1, 0, 0, 0, 0, '0);
        check("R6 trap to level3", {59'b0, outcome}, {59'b0, E_T3});
        check("R6 class 0x18", {56'b0, exc_class}, 64'h18);
        req(2'd2, 1, 0, 0, 1, 0, 1, 0, 0, '0);
        check("R6 halted only still traps", {59'b0, outcome}, {59'b0, E_T3});
        req(2'd2, 1, 0, 0, 1, 0, 1, 1, 0, '0);
        check("R7 debug lock undefined", {59'b0, outcome}, {59'b0, E_UND});
        check("R7 early ordering undefined", {59'b0, outcome_e2}, {59'b0, E_UND});
        req(2'd2, 1, 0, 0, 1, 1, 1, 1, 0, '0);
        check("R8 enabled gives direct", {59'b0, outcome}, {59'b0, E_DIR});
        check("R8 early ordering direct", {59'b0, outcome_e2}, {59'b0, E_DIR});
        req(2'd2, 1, 0, 0, 0, 0, 1, 1, 0, '0);
        check("R8 no top level direct", {59'b0, outcome}, {59'b0, E_DIR});
    endtask

    task automatic t_level3();
        req(2'd3, 0, 1, 1, 1, 0, 1, 1, 0, '0);
        check("R8 level3 direct", {59'b0, outcome}, {59'b0, E_DIR});
        check("R9 no class on direct", {56'b0, exc_class}, 64'h0);
    endtask

    task automatic t_write_mask();
        req(2'd3, 0, 0, 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R12 rdata zero on write", rdata, 64'h0);
        req(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        check("R10 only bits 2 and 0 kept", rdata, 64'h5);
        req(2'd2, 0, 0, 0, 1, 1, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFA);
        req(2'd2, 0, 0, 0, 1, 1, 0, 0, 0, '0);
        check("R10 reserved bits read zero", rdata, 64'h0);
        req(2'd3, 0, 0, 0, 0, 0, 0, 0, 1, 64'h4);
        req(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        check("R10 bit2 stored", rdata, 64'h4);
    endtask

    task automatic t_blocked_write();
        req(2'd1, 1, 1, 0, 0, 0, 0, 0, 1, 64'h1);
        req(2'd1, 1, 1, 1, 0, 0, 0, 0, 1, 64'h1);
        req(2'd2, 0, 0, 0, 1, 0, 0, 0, 1, 64'h1);
        req(2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h1);
        req(2'd1, 1, 1, 0, 0, 0, 0, 0, 0, '0);
        check("R12 rdata zero on trap read", rdata, 64'h0);
        req(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        check("R11 blocked writes dropped", rdata, 64'h4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level0();
        t_level1();
        t_level2();
        t_level3();
        t_write_mask();
        t_blocked_write();
        idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule